// File: doc/BRIEF.md
# Configurable UART frame engine

This block holds the transmit and receive frame logic of a multi-mode serial port for its two character-oriented modes: asynchronous operation timed by an internal baud divider, and synchronous operation clocked by an external serial clock. It serializes a parallel word of 5 to 9 bits into a frame with a start bit, an optional parity bit and a stop bit. It also deserializes incoming frames, checks their parity and stop bit, and reports the result.

An 8-bit control word sets the framing. Bits [1:0] select the link mode, bits [3:2] the parity mode, bits [6:4] the word length code and bit 7 the serial clock polarity. The surrounding port provides the control word, the baud divisor and the data handshake. The block does not include FIFOs, interrupts or bus access.

Top module: `uart_frame_engine`

## Requirements
- R1: ctrl[1:0] selects the link mode: 00 asynchronous, 01 synchronous, 10 handled as asynchronous, 11 inactive. When inactive, txd stays high, tx_start and rxd have no effect, and neither tx_done nor rx_done pulses.
- R2: ctrl[3:2] selects parity: 00 none, 10 even, 11 odd, 01 handled as none. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number.
- R3: ctrl[6:4] selects the word length: 000 = 5, 001 = 6, 010 = 7, 011 = 8, 111 = 9 bits, and 100/101/110 are handled as 8 bits. A ctrl value of 8'h00 gives asynchronous mode, no parity and 5 data bits.
- R4: A transmit frame is sent in this order: a low start bit, the data bits least-significant first, the parity bit when enabled, and one high stop bit. txd is high when idle. In asynchronous mode each bit lasts 16*(baud_div+1) clock cycles.
- R5: A tx_start pulse is ignored while tx_busy is high. The frame already on the line is not altered, and no extra frame follows.
- R6: tx_done pulses for exactly one cycle when the stop bit ends. In that cycle tx_busy is low and txd is high.
- R7: In asynchronous mode the receiver takes a falling rxd as a start bit only if rxd is still low half a bit later. It samples each later bit at mid-bit. It then delivers rx_data right-aligned, with unused upper bits zero, and pulses rx_done for one cycle.
- R8: rx_parity_err is set with rx_done when parity is enabled and the received parity bit disagrees with the selected parity. It is clear when parity is disabled.
- R9: rx_frame_err is set with rx_done when the received stop bit is low, and clear otherwise.
- R10: In synchronous mode one bit moves per sclk period. With ctrl[7] = 0, txd changes after a rising sclk edge and rxd is sampled on a falling edge. With ctrl[7] = 1 the two edges swap roles. tx_done follows the first drive edge after the stop bit.
- R11: After reset, txd is 1, tx_busy, tx_done and rx_done are 0, rx_data is 0, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 8 | Control word: mode, parity, length, polarity |
| baud_div | input | 16 | Oversample tick divisor; one tick every baud_div+1 cycles |
| sclk | input | 1 | External serial clock for synchronous mode |
| tx_start | input | 1 | Request to send tx_data |
| tx_data | input | 9 | Word to transmit, right-aligned |
| tx_busy | output | 1 | Transmit frame in progress |
| tx_done | output | 1 | One-cycle pulse at end of a transmit frame |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 9 | Last received word, right-aligned |
| rx_done | output | 1 | One-cycle pulse when rx_data is valid |
| rx_parity_err | output | 1 | Parity error on last received word |
| rx_frame_err | output | 1 | Stop bit was low on last received word |

## Verification
The hardest case to produce from the ports is showing that synchronous mode uses the correct edge for each role. Reading the line just before each drive edge gives the same bits whichever edge moved them. The stimulus therefore toggles sclk by hand and reads txd just before each sample edge. If the edges are swapped, the line has not yet moved at that point and the start bit is missed. Parity and stop-bit errors cannot come from the block's own transmitter, so the bench disconnects the loopback and drives rxd directly with deliberately corrupted frames.

// File: rtl/ufe_pkg.sv
package ufe_pkg;
  localparam int MAXD = 9;
  localparam int FRW  = MAXD + 3;

  typedef enum logic [1:0] {
    LINK_ASYNC = 2'b00, LINK_SYNC = 2'b01, LINK_ALT = 2'b10, LINK_OFF = 2'b11
  } link_e;

  typedef struct packed {
    logic [3:0] len;
    logic       par_en;
    logic       par_odd;
    logic       sync;
    logic       active;
    logic       pol;
  } cfg_t;

  // word length from the sparse 3-bit code; unused codes fall back to 8
  function automatic logic [3:0] code_to_len(input logic [2:0] c);
    case (c)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  // control layout: [1:0] link, [3:2] parity, [6:4] length code, [7] polarity
  function automatic cfg_t decode_ctrl(input logic [7:0] r);
    cfg_t c;
    c.len     = code_to_len(r[6:4]);
    c.par_en  = (r[3:2] == 2'b10) || (r[3:2] == 2'b11);
    c.par_odd = (r[3:2] == 2'b11);
    c.sync    = (link_e'(r[1:0]) == LINK_SYNC);
    c.active  = (link_e'(r[1:0]) != LINK_OFF);
    c.pol     = r[7];
    return c;
  endfunction

  function automatic logic [MAXD-1:0] len_mask(input logic [3:0] len);
    logic [MAXD-1:0] m;
    m = '0;
    for (int i = 0; i < MAXD; i++) if (i < int'(len)) m[i] = 1'b1;
    return m;
  endfunction

  // value of the parity bit that completes the selected parity
  function automatic logic parity_of(input logic [MAXD-1:0] d, input logic [3:0] len,
                                     input logic odd);
    return (^(d & len_mask(len))) ^ odd;
  endfunction

  function automatic logic [FRW-1:0] build_frame(input logic [MAXD-1:0] d,
                                                 input logic [3:0] len,
                                                 input logic pen, input logic odd);
    logic [FRW-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < MAXD; i++) if (i < int'(len)) f[i+1] = d[i];
    if (pen) f[int'(len)+1] = parity_of(d, len, odd);
    return f;
  endfunction

  function automatic logic [3:0] frame_bits(input logic [3:0] len, input logic pen);
    return len + {3'b000, pen} + 4'd2;
  endfunction
endpackage

// File: rtl/ufe_timing.sv
module ufe_timing #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             sclk,
  input  logic             pol,
  output logic             tick,
  output logic             drv_edge,
  output logic             smp_edge
);
  logic [DIV_W-1:0] bcnt;
  logic [2:0]       ssync;
  logic             rise, fall;

  assign tick = (bcnt >= baud_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (tick) bcnt <= '0;
    else bcnt <= bcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ssync <= 3'b000;
    else ssync <= {ssync[1:0], sclk};
  end

  assign rise     = ssync[1] & ~ssync[2];
  assign fall     = ~ssync[1] & ssync[2];
  assign drv_edge = pol ? fall : rise;
  assign smp_edge = pol ? rise : fall;
endmodule

// File: rtl/ufe_tx.sv
module ufe_tx
  import ufe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_t            cfg,
  input  logic            tick,
  input  logic            drv_edge,
  input  logic            start,
  input  logic [MAXD-1:0] data,
  output logic            txd,
  output logic            busy,
  output logic            done
);
  localparam int SUBW = $clog2(OVS);

  logic [FRW-1:0]  frame;
  logic [3:0]      left;
  logic [SUBW-1:0] sub;
  logic            shown;
  logic            tx_step;

  assign tx_step = cfg.sync ? drv_edge : (tick && sub == SUBW'(OVS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '1; left <= '0; sub <= '0; shown <= 1'b0;
      busy <= 1'b0; txd <= 1'b1; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!cfg.active) begin
        busy <= 1'b0; txd <= 1'b1; shown <= 1'b0;
      end else if (!busy) begin
        if (start) begin
          frame <= build_frame(data, cfg.len, cfg.par_en, cfg.par_odd);
          left  <= frame_bits(cfg.len, cfg.par_en);
          busy  <= 1'b1;
          sub   <= '0;
          shown <= !cfg.sync;
          txd   <= cfg.sync;
        end
      end else begin
        if (!cfg.sync && tick) sub <= (sub == SUBW'(OVS-1)) ? '0 : sub + 1'b1;
        if (tx_step) begin
          if (!shown) begin
            shown <= 1'b1; txd <= frame[0];
          end else if (left == 4'd1) begin
            busy <= 1'b0; done <= 1'b1; txd <= 1'b1; shown <= 1'b0;
          end else begin
            frame <= {1'b1, frame[FRW-1:1]};
            txd   <= frame[1];
            left  <= left - 1'b1;
          end
        end
      end
    end
  end

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shown) |-> !txd);
  assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tx_step && cfg.active |=> $stable(frame) && $stable(left));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && txd);
endmodule

// File: rtl/ufe_rx.sv
module ufe_rx
  import ufe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_t            cfg,
  input  logic            tick,
  input  logic            smp_edge,
  input  logic            rxd,
  output logic [MAXD-1:0] data,
  output logic            done,
  output logic            perr,
  output logic            ferr
);
  localparam int SUBW = $clog2(OVS);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxst_e;

  rxst_e           st;
  logic [1:0]      rsync;
  logic            rxs;
  logic [SUBW-1:0] sub;
  logic [3:0]      idx, plen;
  logic            ppen, podd, pbit;
  logic [MAXD-1:0] sbuf;
  logic            rx_samp, rx_half;

  assign rxs     = rsync[1];
  assign rx_samp = cfg.sync ? smp_edge : (tick && sub == SUBW'(OVS-1));
  assign rx_half = tick && sub == SUBW'(OVS/2-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b11;
    else rsync <= {rsync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; sub <= '0; idx <= '0; plen <= 4'd5; ppen <= 1'b0; podd <= 1'b0;
      pbit <= 1'b0; sbuf <= '0; data <= '0; done <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!cfg.active) st <= RX_IDLE;
      else begin
        case (st)
          RX_IDLE: begin
            sub <= '0; idx <= '0; sbuf <= '0;
            plen <= cfg.len; ppen <= cfg.par_en; podd <= cfg.par_odd;
            if (cfg.sync) begin
              if (smp_edge && !rxs) st <= RX_BITS;
            end else if (!rxs) st <= RX_START;
          end
          RX_START: begin
            if (tick) sub <= sub + 1'b1;
            if (rx_half) begin
              sub <= '0;
              st  <= rxs ? RX_IDLE : RX_BITS;
            end
          end
          default: begin
            if (!cfg.sync && tick) sub <= (sub == SUBW'(OVS-1)) ? '0 : sub + 1'b1;
            if (rx_samp) begin
              if (idx < plen) sbuf[idx] <= rxs;
              else if (ppen && idx == plen) pbit <= rxs;
              else begin
                data <= sbuf;
                perr <= ppen && (parity_of(sbuf, plen, podd) != pbit);
                ferr <= !rxs;
                done <= 1'b1;
                st   <= RX_IDLE;
              end
              idx <= idx + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assert_rx_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (data & ~len_mask(plen)) == '0);
  assert_perr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ppen |-> !perr);
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import ufe_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ctrl,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             sclk,
  input  logic             tx_start,
  input  logic [MAXD-1:0]  tx_data,
  output logic             tx_busy,
  output logic             tx_done,
  output logic             txd,
  input  logic             rxd,
  output logic [MAXD-1:0]  rx_data,
  output logic             rx_done,
  output logic             rx_parity_err,
  output logic             rx_frame_err
);
  cfg_t cfg;
  logic tick, drv_edge, smp_edge;

  assign cfg = decode_ctrl(ctrl);

  ufe_timing #(.DIV_W(DIV_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .sclk(sclk), .pol(cfg.pol),
    .tick(tick), .drv_edge(drv_edge), .smp_edge(smp_edge)
  );

  ufe_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tick(tick), .drv_edge(drv_edge),
    .start(tx_start), .data(tx_data), .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  ufe_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tick(tick), .smp_edge(smp_edge), .rxd(rxd),
    .data(rx_data), .done(rx_done), .perr(rx_parity_err), .ferr(rx_frame_err)
  );

  assert_inactive_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.active |=> !tx_done && !rx_done && txd);
endmodule

// File: tb/sim_uart_frame_engine.sv
`timescale 1ns/1ps
module sim_uart_frame_engine;
  typedef struct packed {
    logic [7:0] ctrl;
    logic [8:0] data;
    logic [1:0] div;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [0:NV-1] = '{
    '{8'h00, 9'h015, 2'd0},   // 5 bit, no parity (all-zero control)
    '{8'h18, 9'h02D, 2'd0},   // 6 bit even
    '{8'h2C, 9'h055, 2'd1},   // 7 bit odd, slower divisor
    '{8'h38, 9'h0A7, 2'd0},   // 8 bit even
    '{8'h7C, 9'h1C3, 2'd0},   // 9 bit odd
    '{8'h50, 9'h1FF, 2'd0},   // unused length code 101 -> 8 bit
    '{8'h34, 9'h081, 2'd0},   // unused parity code 01 -> none
    '{8'h7A, 9'h0FF, 2'd0},   // link code 10 -> asynchronous, 9 bit even
    '{8'h0C, 9'h1EA, 2'd2}    // 5 bit odd, upper data bits set
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic [15:0] baud_div = 16'd0;
  logic       sclk = 1'b0;
  logic       tx_start = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_busy, tx_done, txd;
  logic       rxd_drv = 1'b1;
  logic       loopback = 1'b0;
  logic       rxd_w;
  logic [8:0] rx_data;
  logic       rx_done, rx_parity_err, rx_frame_err;

  int checks = 0;
  int errors = 0;
  int tx_cnt = 0;
  int rx_cnt = 0;
  logic [8:0] cap_data = '0;
  logic       cap_perr = 1'b0;
  logic       cap_ferr = 1'b0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;
  assign rxd_w = loopback ? txd : rxd_drv;

  uart_frame_engine u0 (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .baud_div(baud_div), .sclk(sclk),
    .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy), .tx_done(tx_done),
    .txd(txd), .rxd(rxd_w), .rx_data(rx_data), .rx_done(rx_done),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_done) tx_cnt++;
      if (rx_done) begin
        rx_cnt++;
        cap_data = rx_data; cap_perr = rx_parity_err; cap_ferr = rx_frame_err;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench view of the control word
  function automatic int b_len(input logic [7:0] c);
    if (c[6:4] == 3'b111) return 9;
    if (c[6] == 1'b1) return 8;
    return 5 + int'(c[5:4]);
  endfunction
  function automatic bit b_pen(input logic [7:0] c);
    return c[3];
  endfunction
  function automatic int b_nbits(input logic [7:0] c);
    return b_len(c) + (b_pen(c) ? 1 : 0) + 2;
  endfunction
  function automatic logic [8:0] b_word(input logic [7:0] c, input logic [8:0] d);
    logic [8:0] w;
    w = '0;
    for (int i = 0; i < b_len(c); i++) w[i] = d[i];
    return w;
  endfunction
  function automatic logic [11:0] b_frame(input logic [7:0] c, input logic [8:0] d);
    logic [11:0] f;
    int ones, n;
    n = b_len(c);
    ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[i+1] = d[i];
      if (d[i]) ones++;
    end
    if (b_pen(c)) f[n+1] = (c[2] ? (ones % 2 == 0) : (ones % 2 == 1));
    return f;
  endfunction

  task automatic tx_vec(input logic [7:0] c, input logic [8:0] d, input int dv,
                        input bit glitch, input string req);
    logic [11:0] expf, got;
    int n, bitc, t0, r0;
    ctrl = c; baud_div = 16'(dv); loopback = 1'b1;
    repeat (4) @(negedge clk);
    expf = b_frame(c, d); n = b_nbits(c); bitc = 16 * (dv + 1);
    got = '1; t0 = tx_cnt; r0 = rx_cnt;
    tx_data = d; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    repeat (bitc / 2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      got[k] = txd;
      if (glitch && k == 2) begin
        tx_start = 1'b1; tx_data = ~d;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (bitc - 1) @(negedge clk);
      end else repeat (bitc) @(negedge clk);
    end
    repeat (bitc) @(negedge clk);
    check(req, "tx frame bits (R4)", 32'(got), 32'(expf));
    check(glitch ? "R5" : "R6", "tx_done count", 32'(tx_cnt - t0), 32'd1);
    check("R7", "rx word count", 32'(rx_cnt - r0), 32'd1);
    check(req, "rx word (R7)", 32'(cap_data), 32'(b_word(c, d)));
    check("R8", "rx parity flag", 32'(cap_perr), 32'd0);
    check("R9", "rx frame flag", 32'(cap_ferr), 32'd0);
    loopback = 1'b0;
  endtask

  task automatic rx_raw(input logic [11:0] f, input int n);
    loopback = 1'b0;
    for (int k = 0; k < n; k++) begin
      rxd_drv = f[k];
      repeat (16) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic sync_run(input logic pol, input logic [8:0] d, input string req);
    logic [7:0] c;
    logic [11:0] expf, got;
    int n, t0, r0;
    c = {pol, 3'b011, 2'b10, 2'b01};
    sclk = pol; ctrl = c; loopback = 1'b1;
    repeat (10) @(negedge clk);
    expf = b_frame(c, d); n = b_nbits(c); got = '1; t0 = tx_cnt; r0 = rx_cnt;
    tx_data = d; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k <= n; k++) begin
      sclk = ~sclk;                       // drive edge
      repeat (7) @(negedge clk);
      if (k < n) got[k] = txd;            // just before the sample edge
      @(negedge clk);
      sclk = ~sclk;                       // sample edge
      repeat (8) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check(req, "sync tx bits before sample edge", 32'(got), 32'(expf));
    check(req, "sync tx_done count", 32'(tx_cnt - t0), 32'd1);
    check(req, "sync rx word", 32'(cap_data), 32'(b_word(c, d)));
    check(req, "sync rx count", 32'(rx_cnt - r0), 32'd1);
    loopback = 1'b0;
    ctrl = 8'h00;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "txd after reset", 32'(txd), 32'd1);
    check("R11", "tx_busy after reset", 32'(tx_busy), 32'd0);
    check("R11", "done strobes after reset", 32'({tx_done, rx_done}), 32'd0);
    check("R11", "rx_data after reset", 32'(rx_data), 32'd0);
    check("R11", "error flags after reset", 32'({rx_parity_err, rx_frame_err}), 32'd0);

    // vector table: R1 R2 R3 R4 R6 R7 through loopback
    for (int v = 0; v < NV; v++)
      tx_vec(VEC[v].ctrl, VEC[v].data, int'(VEC[v].div), 1'b0, "R2/R3");

    // R5 start pulse while busy
    tx_vec(8'h38, 9'h03C, 0, 1'b1, "R5");

    // R8 wrong parity: 8 bit even, data 0x0F has four ones, parity sent as 1
    ctrl = 8'h38; baud_div = 16'd0;
    repeat (4) @(negedge clk);
    begin
      int r0;
      r0 = rx_cnt;
      rx_raw({1'b1, 1'b1, 8'h0F, 1'b0}, 11);
      check("R8", "bad parity count", 32'(rx_cnt - r0), 32'd1);
      check("R8", "bad parity flag", 32'(cap_perr), 32'd1);
      check("R9", "stop ok with bad parity", 32'(cap_ferr), 32'd0);
      check("R8", "word with bad parity", 32'(cap_data), 32'h0F);
    end

    // R9 low stop bit, 7 bit odd, data 0x03 (two ones -> parity 1)
    ctrl = 8'h2C;
    repeat (4) @(negedge clk);
    rx_raw({1'b0, 1'b1, 7'h03, 1'b0}, 10);
    check("R9", "low stop flag", 32'(cap_ferr), 32'd1);
    check("R8", "odd parity accepted", 32'(cap_perr), 32'd0);
    rxd_drv = 1'b1;
    repeat (200) @(negedge clk);

    // R7 short low glitch on rxd is not a start bit
    ctrl = 8'h38;
    begin
      int r0;
      r0 = rx_cnt;
      rxd_drv = 1'b0;
      repeat (3) @(negedge clk);
      rxd_drv = 1'b1;
      repeat (300) @(negedge clk);
      check("R7", "glitch ignored", 32'(rx_cnt - r0), 32'd0);
    end

    // R10 synchronous mode, both polarities
    sync_run(1'b0, 9'h0B4, "R10");
    sync_run(1'b1, 9'h04B, "R10");

    // R1 inactive link code 11
    ctrl = 8'h3B;
    repeat (4) @(negedge clk);
    begin
      int t0, r0, lows;
      t0 = tx_cnt; r0 = rx_cnt; lows = 0;
      tx_data = 9'h000; tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      for (int i = 0; i < 220; i++) begin
        if (!txd) lows++;
        @(negedge clk);
      end
      rx_raw({1'b1, 1'b0, 8'h55, 1'b0}, 11);
      check("R1", "txd low cycles when inactive", 32'(lows), 32'd0);
      check("R1", "tx_done when inactive", 32'(tx_cnt - t0), 32'd0);
      check("R1", "rx_done when inactive", 32'(rx_cnt - r0), 32'd0);
      check("R1", "tx_busy when inactive", 32'(tx_busy), 32'd0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule